// File: doc/BRIEF.md
# Coherence directory home controller

This block is the home node of a directory-based cache coherence scheme for a fixed number of caching sites. For every memory block it holds a state and a bit vector with one bit per site. In the readable state the vector lists the sharers. In the owned state it marks the single owner. In the two waiting states it marks the sites whose replies are still outstanding. A small internal array stands in for the memory bank behind the directory.

Caches talk to the home node through one inbound message port. Every inbound message carries a site id, a message code, a block address and a data word, and the same port carries both requests and replies. Outbound messages leave through one registered outbound port with the same fields. Both ports use a valid/ready handshake. A shared request returns data and adds the requester to the sharers. An exclusive request may first need invalidations, a write-back or a flush before ownership is granted.

The controller works on one coherence transaction at a time. While a block is waiting for acknowledgements or for data, the controller refuses new requests but still accepts replies. Replies that do not belong to the open transaction are consumed and have no effect.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every block is readable with no sharers, memory word i holds INIT_BASE + i, out_valid is low, and in_ready is high for a request. Inbound codes: 0 shared request, 1 exclusive request, 2 write-back reply, 3 invalidate reply, 4 flush reply. Outbound codes: 0 shared reply, 1 exclusive reply, 2 write-back request, 3 invalidate request, 4 flush request.
- R2: A shared request (code 0) for a readable block returns a shared reply (code 0) to the requester, carrying the memory word, and adds the requester to the sharer set.
- R3: An exclusive request (code 1) for a readable block whose sharer set holds no site other than the requester is answered at once with an exclusive reply (code 1) carrying the memory word, and the requester becomes the owner.
- R4: An exclusive request for a readable block that has other sharers sends one invalidate request (code 3) to each of those other sharers, in ascending site order, and sends no reply to the requester yet.
- R5: Each matching invalidate reply (code 3) removes its site from the pending set. Only when the set is empty does the requester receive an exclusive reply with the memory word and become the owner. The pending set never grows during this wait.
- R6: A shared request for an owned block sends a write-back request (code 2) to the owner. The write-back reply (code 2) from the owner writes its data into memory and returns a shared reply with that data to the requester. The block then becomes readable, with both the old owner and the requester as sharers.
- R7: An exclusive request for an owned block sends a flush request (code 4) to the owner. The flush reply (code 4) from the owner writes its data into memory and returns an exclusive reply with that data to the requester, who becomes the sole owner.
- R8: While a transaction waits for invalidate, write-back or flush replies, in_ready stays low for any request. The request is accepted only after the transaction completes.
- R9: An outbound message is held with all fields stable while out_valid is high and out_ready is low.
- R10: A reply with the wrong code, from a site outside the awaited set, for another block, or arriving when no transaction is open, is accepted and changes neither the memory nor the directory, and causes no outbound message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Inbound message valid |
| in_ready | output | 1 | Inbound message accepted this cycle when valid |
| in_site | input | SITE_W | Sending site |
| in_kind | input | 3 | Inbound message code |
| in_addr | input | ADDR_W | Block address |
| in_data | input | DATA_W | Data carried by write-back and flush replies |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Network takes the outbound message |
| out_site | output | SITE_W | Destination site |
| out_kind | output | 3 | Outbound message code |
| out_addr | output | ADDR_W | Block address |
| out_data | output | DATA_W | Data carried by shared and exclusive replies |

## Verification
The assertions check on every cycle that an outbound message is held until it is taken, and that requests are refused while a transaction is open. They also check that invalidate, write-back and flush requests appear only in the matching waiting phase, and that the set of awaited acknowledgements only shrinks. The data a reply carries, the ascending order of invalidations, the final sharer or owner of a block and the absence of any effect from stray replies can only be shown by the bench's scenarios. The bench compares every outbound message against its reference model and observes the later replies for the affected blocks.

// File: rtl/dir_home_pkg.sv
`timescale 1ns/1ps
package dir_home_pkg;

   typedef enum logic [1:0] {
      BLK_R  = 2'd0,
      BLK_W  = 2'd1,
      BLK_TR = 2'd2,
      BLK_TW = 2'd3
   } blk_state_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_INV   = 2'd1,
      PH_FETCH = 2'd2
   } phase_e;

   localparam logic [2:0] IN_SH_REQ    = 3'd0;
   localparam logic [2:0] IN_EX_REQ    = 3'd1;
   localparam logic [2:0] IN_WB_REP    = 3'd2;
   localparam logic [2:0] IN_INV_REP   = 3'd3;
   localparam logic [2:0] IN_FLUSH_REP = 3'd4;

   localparam logic [2:0] OUT_SH_REP    = 3'd0;
   localparam logic [2:0] OUT_EX_REP    = 3'd1;
   localparam logic [2:0] OUT_WB_REQ    = 3'd2;
   localparam logic [2:0] OUT_INV_REQ   = 3'd3;
   localparam logic [2:0] OUT_FLUSH_REQ = 3'd4;

endpackage

// File: rtl/dir_tag_table.sv
`timescale 1ns/1ps
module dir_tag_table
   import dir_home_pkg::*;
#(
   parameter int N_BLOCKS = 8,
   parameter int N_SITES  = 4,
   parameter int ADDR_W   = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   output blk_state_e         rd_state,
   output logic [N_SITES-1:0] rd_vec,
   input  logic               wr_en,
   input  blk_state_e         wr_state,
   input  logic [N_SITES-1:0] wr_vec
);

   blk_state_e         st_q  [N_BLOCKS];
   logic [N_SITES-1:0] vec_q [N_BLOCKS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_BLOCKS; i++) begin
            st_q[i]  <= BLK_R;
            vec_q[i] <= '0;
         end
      end else if (wr_en) begin
         st_q[addr]  <= wr_state;
         vec_q[addr] <= wr_vec;
      end
   end

   assign rd_state = st_q[addr];
   assign rd_vec   = vec_q[addr];

endmodule

// File: rtl/dir_data_ram.sv
`timescale 1ns/1ps
module dir_data_ram #(
   parameter int N_BLOCKS  = 8,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int INIT_BASE = 'h0A00
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] mem_q [N_BLOCKS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_BLOCKS; i++) begin
            mem_q[i] <= DATA_W'(INIT_BASE) + DATA_W'(i);
         end
      end else if (wr_en) begin
         mem_q[addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[addr];

endmodule

// File: rtl/dir_lsb_pick.sv
`timescale 1ns/1ps
module dir_lsb_pick #(
   parameter int N  = 4,
   parameter int IW = 2
)(
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);

   logic [N-1:0] first;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_first
         if (g == 0) begin : g_lo
            assign first[g] = vec[g];
         end else begin : g_hi
            assign first[g] = vec[g] & ~(|vec[g-1:0]);
         end
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (first[i]) idx = idx | IW'(i);
      end
   end

   assign any = |vec;

endmodule

// File: rtl/dir_home_ctrl.sv
`timescale 1ns/1ps
module dir_home_ctrl
   import dir_home_pkg::*;
#(
   parameter int N_SITES   = 4,
   parameter int N_BLOCKS  = 8,
   parameter int DATA_W    = 16,
   parameter int INIT_BASE = 'h0A00,
   parameter int SITE_W    = $clog2(N_SITES),
   parameter int ADDR_W    = $clog2(N_BLOCKS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [SITE_W-1:0] in_site,
   input  logic [2:0]        in_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [SITE_W-1:0] out_site,
   output logic [2:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);

   generate
      if (N_SITES < 2) begin : g_bad_sites
         $error("dir_home_ctrl: N_SITES must be at least 2");
      end
      if (N_BLOCKS < 2 || (N_BLOCKS & (N_BLOCKS - 1)) != 0) begin : g_bad_blocks
         $error("dir_home_ctrl: N_BLOCKS must be a power of two, at least 2");
      end
      if (SITE_W != $clog2(N_SITES) || ADDR_W != $clog2(N_BLOCKS)) begin : g_bad_widths
         $error("dir_home_ctrl: SITE_W and ADDR_W must follow N_SITES and N_BLOCKS");
      end
      if (DATA_W < 1 || INIT_BASE < 0) begin : g_bad_data
         $error("dir_home_ctrl: DATA_W must be positive and INIT_BASE non-negative");
      end
   endgenerate

   // transaction state
   phase_e             phase_q, phase_n;
   logic [ADDR_W-1:0]  pend_addr_q, pend_addr_n;
   logic [SITE_W-1:0]  pend_site_q, pend_site_n;
   logic               pend_ex_q, pend_ex_n;
   logic [N_SITES-1:0] todo_q, todo_n;

   // outbound register
   logic               out_valid_q;
   logic [SITE_W-1:0]  out_site_q;
   logic [2:0]         out_kind_q;
   logic [ADDR_W-1:0]  out_addr_q;
   logic [DATA_W-1:0]  out_data_q;
   logic               ld;
   logic [SITE_W-1:0]  ld_site;
   logic [2:0]         ld_kind;
   logic [DATA_W-1:0]  ld_data;

   // directory and memory access
   logic [ADDR_W-1:0]  blk_addr;
   blk_state_e         tb_state, tb_wst;
   logic [N_SITES-1:0] tb_vec, tb_wvec;
   logic               tb_we;
   logic [DATA_W-1:0]  mem_rd;
   logic               mem_we;

   logic               in_is_req, out_free, in_fire, in_match;
   logic [N_SITES-1:0] in_bit, pend_bit, vec_left;
   logic [SITE_W-1:0]  owner_idx, todo_idx;
   logic               owner_any, todo_any;

   assign in_is_req = (in_kind == IN_SH_REQ) || (in_kind == IN_EX_REQ);
   assign out_free  = !out_valid_q || out_ready;
   assign in_ready  = out_free && (!in_is_req || phase_q == PH_IDLE);
   assign in_fire   = in_valid && in_ready;
   assign blk_addr  = (phase_q == PH_IDLE) ? in_addr : pend_addr_q;
   assign in_bit    = N_SITES'(1) << in_site;
   assign pend_bit  = N_SITES'(1) << pend_site_q;
   assign in_match  = (in_addr == pend_addr_q) && tb_vec[in_site];

   dir_tag_table #(
      .N_BLOCKS (N_BLOCKS),
      .N_SITES  (N_SITES),
      .ADDR_W   (ADDR_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (blk_addr),
      .rd_state (tb_state),
      .rd_vec   (tb_vec),
      .wr_en    (tb_we),
      .wr_state (tb_wst),
      .wr_vec   (tb_wvec)
   );

   dir_data_ram #(
      .N_BLOCKS  (N_BLOCKS),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .INIT_BASE (INIT_BASE)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (blk_addr),
      .rd_data (mem_rd),
      .wr_en   (mem_we),
      .wr_data (in_data)
   );

   dir_lsb_pick #(.N(N_SITES), .IW(SITE_W)) u_owner_pick (
      .vec (tb_vec),
      .idx (owner_idx),
      .any (owner_any)
   );

   dir_lsb_pick #(.N(N_SITES), .IW(SITE_W)) u_todo_pick (
      .vec (todo_q),
      .idx (todo_idx),
      .any (todo_any)
   );

   always_comb begin
      phase_n     = phase_q;
      pend_addr_n = pend_addr_q;
      pend_site_n = pend_site_q;
      pend_ex_n   = pend_ex_q;
      todo_n      = todo_q;
      tb_we       = 1'b0;
      tb_wst      = tb_state;
      tb_wvec     = tb_vec;
      mem_we      = 1'b0;
      ld          = 1'b0;
      ld_site     = in_site;
      ld_kind     = OUT_SH_REP;
      ld_data     = '0;
      vec_left    = tb_vec;
      case (phase_q)
         PH_IDLE: begin
            if (in_fire && in_is_req) begin
               pend_addr_n = in_addr;
               pend_site_n = in_site;
               pend_ex_n   = (in_kind == IN_EX_REQ);
               case (tb_state)
                  BLK_R: begin
                     tb_we = 1'b1;
                     if (in_kind == IN_SH_REQ) begin
                        tb_wst  = BLK_R;
                        tb_wvec = tb_vec | in_bit;
                        ld      = 1'b1;
                        ld_kind = OUT_SH_REP;
                        ld_data = mem_rd;
                     end else if ((tb_vec & ~in_bit) == '0) begin
                        tb_wst  = BLK_W;
                        tb_wvec = in_bit;
                        ld      = 1'b1;
                        ld_kind = OUT_EX_REP;
                        ld_data = mem_rd;
                     end else begin
                        tb_wst  = BLK_TR;
                        tb_wvec = tb_vec & ~in_bit;
                        todo_n  = tb_vec & ~in_bit;
                        phase_n = PH_INV;
                     end
                  end
                  BLK_W: begin
                     if (owner_any) begin
                        tb_we   = 1'b1;
                        tb_wst  = BLK_TW;
                        ld      = 1'b1;
                        ld_site = owner_idx;
                        ld_kind = (in_kind == IN_EX_REQ) ? OUT_FLUSH_REQ : OUT_WB_REQ;
                        phase_n = PH_FETCH;
                     end
                  end
                  default: ;
               endcase
            end
         end
         PH_INV: begin
            if (in_fire && in_kind == IN_INV_REP && in_match) begin
               vec_left = tb_vec & ~in_bit;
               tb_we    = 1'b1;
               tb_wst   = BLK_TR;
               tb_wvec  = vec_left;
            end
            if (todo_any) begin
               if (out_free) begin
                  ld      = 1'b1;
                  ld_site = todo_idx;
                  ld_kind = OUT_INV_REQ;
                  todo_n  = todo_q & ~(N_SITES'(1) << todo_idx);
               end
            end else if (vec_left == '0 && out_free) begin
               tb_we   = 1'b1;
               tb_wst  = BLK_W;
               tb_wvec = pend_bit;
               ld      = 1'b1;
               ld_site = pend_site_q;
               ld_kind = OUT_EX_REP;
               ld_data = mem_rd;
               phase_n = PH_IDLE;
            end
         end
         PH_FETCH: begin
            if (in_fire && in_match &&
                in_kind == (pend_ex_q ? IN_FLUSH_REP : IN_WB_REP)) begin
               mem_we  = 1'b1;
               tb_we   = 1'b1;
               ld      = 1'b1;
               ld_site = pend_site_q;
               ld_data = in_data;
               phase_n = PH_IDLE;
               if (pend_ex_q) begin
                  tb_wst  = BLK_W;
                  tb_wvec = pend_bit;
                  ld_kind = OUT_EX_REP;
               end else begin
                  tb_wst  = BLK_R;
                  tb_wvec = tb_vec | pend_bit;
                  ld_kind = OUT_SH_REP;
               end
            end
         end
         default: phase_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         pend_addr_q <= '0;
         pend_site_q <= '0;
         pend_ex_q   <= 1'b0;
         todo_q      <= '0;
      end else begin
         phase_q     <= phase_n;
         pend_addr_q <= pend_addr_n;
         pend_site_q <= pend_site_n;
         pend_ex_q   <= pend_ex_n;
         todo_q      <= todo_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         out_site_q  <= '0;
         out_kind_q  <= '0;
         out_addr_q  <= '0;
         out_data_q  <= '0;
      end else if (ld) begin
         out_valid_q <= 1'b1;
         out_site_q  <= ld_site;
         out_kind_q  <= ld_kind;
         out_addr_q  <= blk_addr;
         out_data_q  <= ld_data;
      end else if (out_ready) begin
         out_valid_q <= 1'b0;
      end
   end

   assign out_valid = out_valid_q;
   assign out_site  = out_site_q;
   assign out_kind  = out_kind_q;
   assign out_addr  = out_addr_q;
   assign out_data  = out_data_q;

endmodule

// File: rtl/dir_home_ctrl_chk.sv
`timescale 1ns/1ps
module dir_home_ctrl_chk
   import dir_home_pkg::*;
#(
   parameter int N_SITES = 4,
   parameter int SITE_W  = 2,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 16
)(
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [2:0]         in_kind,
   input logic               out_valid,
   input logic               out_ready,
   input logic [SITE_W-1:0]  out_site,
   input logic [2:0]         out_kind,
   input logic [ADDR_W-1:0]  out_addr,
   input logic [DATA_W-1:0]  out_data,
   input logic [1:0]         phase,
   input logic [N_SITES-1:0] blk_vec
);

   // R9: a stalled outbound message keeps every field
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_site) && $stable(out_kind)
                                  && $stable(out_addr) && $stable(out_data));

   // R8: requests are refused while a transaction is open
   p_hold_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) && in_valid && (in_kind == IN_SH_REQ || in_kind == IN_EX_REQ)
      |-> !in_ready);

   // R4: an invalidate request only exists in the invalidation phase
   p_inv_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == OUT_INV_REQ |-> phase == PH_INV);

   // R6: a write-back request only exists while waiting for owner data
   p_wb_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == OUT_WB_REQ |-> phase == PH_FETCH);

   // R7: a flush request only exists while waiting for owner data
   p_flush_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == OUT_FLUSH_REQ |-> phase == PH_FETCH);

   // R5: the set of awaited acknowledgements never gains a site
   p_ack_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_INV && $past(phase == PH_INV) |-> (blk_vec & ~$past(blk_vec)) == '0);

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
   .N_SITES (N_SITES),
   .SITE_W  (SITE_W),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_kind   (in_kind),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_site  (out_site),
   .out_kind  (out_kind),
   .out_addr  (out_addr),
   .out_data  (out_data),
   .phase     (phase_q),
   .blk_vec   (tb_vec)
);

// File: tb/dir_home_ctrl_test.sv
`timescale 1ns/1ps
module dir_home_ctrl_test;

   localparam int NS = 4;
   localparam int NB = 8;
   localparam int DW = 16;
   localparam int IB = 'h0A00;
   localparam int SW = 2;
   localparam int AW = 3;

   // message codes (R1)
   localparam int C_SH_REQ = 0, C_EX_REQ = 1, C_WB_REP = 2, C_INV_REP = 3, C_FL_REP = 4;
   localparam int O_SH_REP = 0, O_EX_REP = 1, O_WB_REQ = 2, O_INV_REQ = 3, O_FL_REQ = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [SW-1:0] in_site = '0;
   logic [2:0]    in_kind = '0;
   logic [AW-1:0] in_addr = '0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [SW-1:0] out_site;
   logic [2:0]    out_kind;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;

   always #2 clk = ~clk;

   dir_home_ctrl #(
      .N_SITES (NS), .N_BLOCKS (NB), .DATA_W (DW), .INIT_BASE (IB)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_site (in_site),
      .in_kind (in_kind), .in_addr (in_addr), .in_data (in_data),
      .out_valid (out_valid), .out_ready (out_ready), .out_site (out_site),
      .out_kind (out_kind), .out_addr (out_addr), .out_data (out_data)
   );

   typedef struct {
      int    site;
      int    kind;
      int    addr;
      int    data;
      string tag;
   } msg_t;

   msg_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   int   unexp = 0;
   int   last_data = -1;

   // reference model: 0 readable, 1 owned, 2 awaiting acks, 3 awaiting data
   int m_st[NB];
   int m_vec[NB];
   int m_mem[NB];
   bit m_busy = 1'b0;
   int m_paddr, m_psite, m_pex;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void push(int s, int k, int a, int d, string tag);
      msg_t m;
      m.site = s; m.kind = k; m.addr = a; m.data = d; m.tag = tag;
      exp_q.push_back(m);
   endfunction

   function automatic void model_request(int s, int k, int a);
      int others;
      if (m_st[a] == 0) begin
         if (k == C_SH_REQ) begin
            push(s, O_SH_REP, a, m_mem[a], "R2");
            m_vec[a] |= (1 << s);
         end else begin
            others = m_vec[a] & ~(1 << s);
            if (others == 0) begin
               push(s, O_EX_REP, a, m_mem[a], "R3");
               m_st[a] = 1; m_vec[a] = 1 << s;
            end else begin
               for (int i = 0; i < NS; i++)
                  if (others[i]) push(i, O_INV_REQ, a, 0, "R4");
               m_st[a] = 2; m_vec[a] = others;
               m_busy = 1'b1; m_paddr = a; m_psite = s; m_pex = 1;
            end
         end
      end else if (m_st[a] == 1) begin
         for (int i = NS - 1; i >= 0; i--) begin
            if (m_vec[a][i]) begin
               if (k == C_EX_REQ) push(i, O_FL_REQ, a, 0, "R7");
               else               push(i, O_WB_REQ, a, 0, "R6");
            end
         end
         m_st[a] = 3;
         m_busy = 1'b1; m_paddr = a; m_psite = s; m_pex = (k == C_EX_REQ);
      end
   endfunction

   function automatic void model_reply(int s, int k, int a, int d);
      if (!m_busy || a != m_paddr || !m_vec[a][s]) return;
      if (m_st[a] == 2 && k == C_INV_REP) begin
         m_vec[a] &= ~(1 << s);
         if (m_vec[a] == 0) begin
            push(m_psite, O_EX_REP, a, m_mem[a], "R5");
            m_st[a] = 1; m_vec[a] = 1 << m_psite; m_busy = 1'b0;
         end
      end else if (m_st[a] == 3 && k == (m_pex ? C_FL_REP : C_WB_REP)) begin
         m_mem[a] = d & 'hFFFF;
         if (m_pex) begin
            push(m_psite, O_EX_REP, a, m_mem[a], "R7");
            m_st[a] = 1; m_vec[a] = 1 << m_psite;
         end else begin
            push(m_psite, O_SH_REP, a, m_mem[a], "R6");
            m_st[a] = 0; m_vec[a] |= (1 << m_psite);
         end
         m_busy = 1'b0;
      end
   endfunction

   // per-clock comparison of the outbound port against the model
   logic          prev_stall = 1'b0;
   logic [SW-1:0] sv_site;
   logic [2:0]    sv_kind;
   logic [AW-1:0] sv_addr;
   logic [DW-1:0] sv_data;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            check(out_valid && out_site == sv_site && out_kind == sv_kind &&
                  out_addr == sv_addr && out_data == sv_data,
                  "R9", "stalled message changed",
                  {out_kind, out_site, out_addr, out_data}, {sv_kind, sv_site, sv_addr, sv_data});
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               unexp++;
               check(1'b0, "R10", "unexpected message kind/site/addr",
                     {out_kind, out_site, out_addr}, 0);
            end else begin
               msg_t m;
               m = exp_q.pop_front();
               check(int'(out_site) == m.site && int'(out_kind) == m.kind &&
                     int'(out_addr) == m.addr && int'(out_data) == m.data,
                     m.tag, "message kind/site/addr/data",
                     {8'(out_kind), 8'(out_site), 8'(out_addr), out_data},
                     {8'(m.kind), 8'(m.site), 8'(m.addr), 16'(m.data)});
            end
            last_data = int'(out_data);
         end
         prev_stall = out_valid && !out_ready;
         sv_site = out_site; sv_kind = out_kind; sv_addr = out_addr; sv_data = out_data;
      end
   end

   task automatic send(input int s, input int k, input int a, input int d);
      in_site = SW'(s); in_kind = 3'(k); in_addr = AW'(a); in_data = DW'(d);
      in_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic req(input int s, input int k, input int a);
      model_request(s, k, a);
      send(s, k, a, 0);
   endtask

   task automatic rep(input int s, input int k, input int a, input int d);
      model_reply(s, k, a, d);
      send(s, k, a, d);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "WD", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) begin
         m_st[i] = 0; m_vec[i] = 0; m_mem[i] = IB + i;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1", "in_ready for request after reset", in_ready, 1);
      @(posedge clk); #1;

      // R2 / R1: shared requests gather sharers and see initial memory
      req(0, C_SH_REQ, 2);
      drain();
      check(last_data == IB + 2, "R1", "initial memory word", last_data, IB + 2);
      req(1, C_SH_REQ, 2);
      req(3, C_SH_REQ, 2);
      drain();

      // R4 / R5: exclusive request with other sharers
      req(1, C_EX_REQ, 2);
      drain();
      // R8: a request during the wait is refused
      in_site = 2'd2; in_kind = 3'(C_SH_REQ); in_addr = 3'd5; in_valid = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(in_ready == 1'b0, "R8", "in_ready during open transaction", in_ready, 0);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      // R10: stray acknowledgements have no effect
      rep(2, C_INV_REP, 2, 0);
      rep(0, C_INV_REP, 3, 0);
      rep(3, C_INV_REP, 2, 0);
      drain();
      check(unexp == 0 && exp_q.size() == 0, "R5", "no early exclusive reply", unexp, 0);
      rep(0, C_INV_REP, 2, 0);
      drain();

      // R6 with R9: write-back while the outbound port stalls
      out_ready = 1'b0;
      req(0, C_SH_REQ, 2);
      repeat (6) @(posedge clk);
      #1 out_ready = 1'b1;
      drain();
      rep(1, C_WB_REP, 2, 'h1234);
      drain();

      // R4 / R5 again with two sharers
      req(2, C_EX_REQ, 2);
      drain();
      rep(0, C_INV_REP, 2, 0);
      rep(1, C_INV_REP, 2, 0);
      drain();

      // R7 with a wrong-code reply ignored (R10)
      req(3, C_EX_REQ, 2);
      drain();
      rep(2, C_WB_REP, 2, 'h7777);
      drain();
      check(unexp == 0, "R10", "wrong-code reply ignored", unexp, 0);
      rep(2, C_FL_REP, 2, 'hBEEF);
      drain();

      // R3: sole sharer and no sharers
      req(1, C_SH_REQ, 6);
      req(1, C_EX_REQ, 6);
      req(0, C_EX_REQ, 7);
      drain();

      // R10: stray reply with no open transaction
      rep(0, C_FL_REP, 4, 'hDEAD);
      drain();
      req(2, C_SH_REQ, 4);
      drain();
      check(last_data == IB + 4, "R10", "memory untouched by stray reply", last_data, IB + 4);

      // R6: memory updated by the write-back
      req(0, C_SH_REQ, 6);
      drain();
      rep(1, C_WB_REP, 6, 'h5555);
      drain();
      req(2, C_SH_REQ, 6);
      drain();
      check(last_data == 'h5555, "R6", "memory after write-back", last_data, 'h5555);
      check(exp_q.size() == 0 && unexp == 0, "R10", "no leftover or extra messages",
            exp_q.size() + unexp, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule